// File: doc/BRIEF.md
# Low-Power Stop Mode Controller

This block sits beside a microcontroller core and manages its low-power stop state. When the core strobes that it has executed a stop instruction, the controller captures five configuration bits in that same cycle. A priority decode of those bits then picks one of five outcomes: an illegal-opcode reset, a debug-friendly light stop that keeps the clocks running, a light stop with the voltage regulator held active, a plain light stop, or a deep stop. The controller drives the internal clock enables and the regulator enable to suit the chosen variant.

While stopped, the controller watches a set of asynchronous wake lines. These are the reset pin, a low-voltage reset, the external interrupt, a parameterised bank of port interrupt pins, a low-voltage warning, ADC conversion complete, the real-time clock, a CAN bus wake-up and a serial receiver. Each line is synchronised on the free-running clock and acted on only at its rising edge. On a qualifying edge the controller first restores the clock enables. One cycle later it issues one of two one-cycle strobes: a reset request with its cause, or an interrupt-vector request with the index of the winning source.

Top module: `stopmode_ctrl`

## Requirements
- R1: A stop strobe with the stop-enable bit at 0 enters no stop state. In the next cycle it produces a one-cycle `rst_req` with `rst_cause` = 0 (illegal opcode), and the clock enables stay high.
- R2: With stop enabled and the debug bit at 1, the block enters mode code 1, whatever the other bits say. The clock enables and `vreg_en` stay high.
- R3: With stop enabled, debug at 0 and both low-voltage bits at 1, the block enters mode code 2. The clock enables go low and `vreg_en` stays high.
- R4: With stop enabled, debug at 0 and either low-voltage bit at 0, the power-down bit picks the mode: 0 gives mode code 3 and 1 gives mode code 4. In both, the clock enables and `vreg_en` go low.
- R5: The configuration bits are captured at the stop strobe. Changing them during stop alters neither `last_mode`, the clock enables nor `vreg_en`.
- R6: During stop in any mode, a reset-pin assertion (low) gives `rst_req` with cause 1, and a low-voltage reset gives cause 2. Both take priority over the interrupt sources.
- R7: In modes 1 to 3, an interrupt wake gives `vec_req` with `vec_src` set to the source index. The indices are: 0 external interrupt, 1..24 port pins 0..23, 25 low-voltage warning, 26 ADC, 27 real-time clock, 28 CAN wake-up, 29 serial receiver. When several sources fire together, the lowest index wins.
- R8: In mode 4, an interrupt wake gives `rst_req` with cause 3 and no `vec_req`.
- R9: The ADC wake line is ignored unless both low-voltage bits were 1 at stop entry.
- R10: Wake lines are edge-qualified. A line already high at stop entry does not wake the block.
- R11: The clock enables come back high in the third cycle after a wake line rises. The one-cycle strobe follows in the fourth cycle. After that, `in_stop` is low.
- R12: `in_stop` is high exactly while stopped. `last_mode` holds the code of the most recently entered stop mode and is 0 after reset.
- R13: A stop strobe that arrives while the block is not in run mode is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running low-speed clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_req | input | 1 | Stop-instruction strobe from the core |
| cfg_stop_en | input | 1 | Stop allowed |
| cfg_dbg_en | input | 1 | Debug enabled, keeps clocks running |
| cfg_lvd_en | input | 1 | Low-voltage detect enabled |
| cfg_lvd_stop_en | input | 1 | Low-voltage detect kept during stop |
| cfg_pwr_down | input | 1 | Selects deep stop |
| pin_rst_n | input | 1 | External reset pin, active low |
| wake_lvd_rst | input | 1 | Low-voltage reset request |
| wake_irq | input | 1 | External interrupt line |
| wake_port | input | NPORT | Port interrupt pins |
| wake_lvw | input | 1 | Low-voltage warning |
| wake_adc | input | 1 | ADC conversion complete |
| wake_rtc | input | 1 | Real-time clock interrupt |
| wake_can | input | 1 | CAN bus wake-up |
| wake_sci | input | 1 | Serial receiver interrupt |
| clk_gate_en | output | NCLK | Internal clock enables |
| vreg_en | output | 1 | Voltage regulator enable |
| rst_req | output | 1 | One-cycle reset request |
| rst_cause | output | 2 | Reset cause, valid with rst_req |
| vec_req | output | 1 | One-cycle interrupt-vector request |
| vec_src | output | IDXW | Winning source index, valid with vec_req |
| in_stop | output | 1 | Currently stopped |
| last_mode | output | 3 | Code of the last entered stop mode |

## Verification
Random configuration words cover every branch of the mode decode, including words where lower-priority bits disagree with the winning one. These show whether the priority order is correct and whether clocks and regulator follow each mode. Each random entry is paired with a random wake source. This separates reset-type exits from vector-type exits and shows whether deep stop turns interrupts into resets. Directed patterns cover three further cases. Simultaneous edges test the priority encoder. A line held high across entry and a masked ADC line test edge qualification and source masking. A stop strobe sent while stopped tests that late strobes are rejected.

// File: rtl/stopmode_pkg.sv
package stopmode_pkg;

  typedef enum logic [2:0] {
    SK_NONE  = 3'd0,
    SK_DBG   = 3'd1,
    SK_REG   = 3'd2,
    SK_LIGHT = 3'd3,
    SK_DEEP  = 3'd4
  } stop_kind_e;

  typedef enum logic [1:0] {
    RC_ILLEGAL = 2'd0,
    RC_PIN     = 2'd1,
    RC_LVD     = 2'd2,
    RC_DEEP    = 2'd3
  } rst_cause_e;

  typedef enum logic [1:0] {
    ST_RUN,
    ST_STOP,
    ST_RESTORE,
    ST_EXIT
  } ctl_state_e;

  typedef struct packed {
    logic stop_en;
    logic dbg_en;
    logic lvd_en;
    logic lvd_stop_en;
    logic pwr_down;
  } stop_cfg_t;

endpackage

// File: rtl/stopmode_decode.sv
module stopmode_decode
  import stopmode_pkg::*;
(
  input  stop_cfg_t  cfg,
  output stop_kind_e kind,
  output logic       adc_ok
);

  logic lvd_kept;

  assign lvd_kept = cfg.lvd_en & cfg.lvd_stop_en;
  assign adc_ok   = lvd_kept;

  // priority: stop enable, then debug, then low-voltage pair, then power-down
  always_comb begin
    if (!cfg.stop_en) begin
      kind = SK_NONE;
    end else if (cfg.dbg_en) begin
      kind = SK_DBG;
    end else if (lvd_kept) begin
      kind = SK_REG;
    end else if (cfg.pwr_down) begin
      kind = SK_DEEP;
    end else begin
      kind = SK_LIGHT;
    end
  end

endmodule

// File: rtl/stopmode_sync.sv
module stopmode_sync #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] rise
);

  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= async_in;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign rise = sync_q & ~prev_q;

endmodule

// File: rtl/stopmode_wake_arb.sv
module stopmode_wake_arb #(
  parameter int unsigned NPORT = 24,
  localparam int unsigned NINT = NPORT + 6,
  localparam int unsigned NSRC = NINT + 2,
  localparam int unsigned IDXW = $clog2(NINT)
) (
  input  logic [NSRC-1:0] rise,
  input  logic            adc_ok,
  output logic            hit_rst,
  output logic            rst_is_pin,
  output logic            hit_int,
  output logic [IDXW-1:0] int_idx
);

  localparam int unsigned ADC_POS = NPORT + 2;
  localparam logic [NINT-1:0] ADC_BIT = NINT'(1) << ADC_POS;

  logic [NINT-1:0] int_raw;
  logic [NINT-1:0] int_masked;

  assign int_raw    = rise[NSRC-1:2];
  assign int_masked = adc_ok ? int_raw : (int_raw & ~ADC_BIT);

  assign rst_is_pin = rise[0];
  assign hit_rst    = rise[0] | rise[1];
  assign hit_int    = |int_masked;

  // lowest index wins: scan from the top so the last hit kept is the lowest
  always_comb begin
    int_idx = '0;
    for (int i = NINT - 1; i >= 0; i--) begin
      if (int_masked[i]) begin
        int_idx = IDXW'(i);
      end
    end
  end

endmodule

// File: rtl/stopmode_ctrl.sv
module stopmode_ctrl
  import stopmode_pkg::*;
#(
  parameter int unsigned NPORT = 24,
  parameter int unsigned NCLK  = 4,
  localparam int unsigned IDXW = $clog2(NPORT + 6)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stop_req,
  input  logic             cfg_stop_en,
  input  logic             cfg_dbg_en,
  input  logic             cfg_lvd_en,
  input  logic             cfg_lvd_stop_en,
  input  logic             cfg_pwr_down,
  input  logic             pin_rst_n,
  input  logic             wake_lvd_rst,
  input  logic             wake_irq,
  input  logic [NPORT-1:0] wake_port,
  input  logic             wake_lvw,
  input  logic             wake_adc,
  input  logic             wake_rtc,
  input  logic             wake_can,
  input  logic             wake_sci,
  output logic [NCLK-1:0]  clk_gate_en,
  output logic             vreg_en,
  output logic             rst_req,
  output logic [1:0]       rst_cause,
  output logic             vec_req,
  output logic [IDXW-1:0]  vec_src,
  output logic             in_stop,
  output logic [2:0]       last_mode
);

  localparam int unsigned NSRC = NPORT + 8;

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_core_q, core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_core_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_core_q <= rst_meta_q;
    end
  end

  assign core_rst_n = rst_core_q;

  // configuration decode
  stop_cfg_t  cfg_now;
  stop_kind_e dec_kind;
  logic       dec_adc_ok;

  assign cfg_now = '{stop_en:     cfg_stop_en,
                     dbg_en:      cfg_dbg_en,
                     lvd_en:      cfg_lvd_en,
                     lvd_stop_en: cfg_lvd_stop_en,
                     pwr_down:    cfg_pwr_down};

  stopmode_decode u_decode (
    .cfg    (cfg_now),
    .kind   (dec_kind),
    .adc_ok (dec_adc_ok)
  );

  // wake synchronisation and arbitration
  logic [NSRC-1:0] wake_async;
  logic [NSRC-1:0] wake_rise;
  logic            hit_rst, rst_is_pin, hit_int;
  logic [IDXW-1:0] int_idx;
  logic            adc_ok_q;

  assign wake_async = {wake_sci, wake_can, wake_rtc, wake_adc, wake_lvw,
                       wake_port, wake_irq, wake_lvd_rst, ~pin_rst_n};

  stopmode_sync #(.W(NSRC)) u_sync (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .async_in (wake_async),
    .rise     (wake_rise)
  );

  stopmode_wake_arb #(.NPORT(NPORT)) u_arb (
    .rise       (wake_rise),
    .adc_ok     (adc_ok_q),
    .hit_rst    (hit_rst),
    .rst_is_pin (rst_is_pin),
    .hit_int    (hit_int),
    .int_idx    (int_idx)
  );

  // control state
  ctl_state_e      state_q, state_d;
  stop_kind_e      mode_q, mode_d;
  stop_kind_e      last_q, last_d;
  rst_cause_e      cause_q, cause_d;
  logic            adc_ok_d;
  logic            exit_rst_q, exit_rst_d;
  logic [IDXW-1:0] src_q, src_d;

  always_comb begin
    state_d    = state_q;
    mode_d     = mode_q;
    last_d     = last_q;
    cause_d    = cause_q;
    adc_ok_d   = adc_ok_q;
    exit_rst_d = exit_rst_q;
    src_d      = src_q;
    unique case (state_q)
      ST_RUN: begin
        if (stop_req) begin
          if (dec_kind == SK_NONE) begin
            state_d    = ST_EXIT;
            exit_rst_d = 1'b1;
            cause_d    = RC_ILLEGAL;
          end else begin
            state_d  = ST_STOP;
            mode_d   = dec_kind;
            last_d   = dec_kind;
            adc_ok_d = dec_adc_ok;
          end
        end
      end
      ST_STOP: begin
        if (hit_rst) begin
          state_d    = ST_RESTORE;
          exit_rst_d = 1'b1;
          cause_d    = rst_is_pin ? RC_PIN : RC_LVD;
        end else if (hit_int) begin
          state_d = ST_RESTORE;
          if (mode_q == SK_DEEP) begin
            exit_rst_d = 1'b1;
            cause_d    = RC_DEEP;
          end else begin
            exit_rst_d = 1'b0;
            src_d      = int_idx;
          end
        end
      end
      ST_RESTORE: state_d = ST_EXIT;
      ST_EXIT:    state_d = ST_RUN;
      default:    state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      state_q    <= ST_RUN;
      mode_q     <= SK_NONE;
      last_q     <= SK_NONE;
      cause_q    <= RC_ILLEGAL;
      adc_ok_q   <= 1'b0;
      exit_rst_q <= 1'b0;
      src_q      <= '0;
    end else begin
      state_q    <= state_d;
      mode_q     <= mode_d;
      last_q     <= last_d;
      cause_q    <= cause_d;
      adc_ok_q   <= adc_ok_d;
      exit_rst_q <= exit_rst_d;
      src_q      <= src_d;
    end
  end

  // outputs
  logic stopped, clocks_on;

  assign stopped   = (state_q == ST_STOP);
  assign clocks_on = !(stopped && (mode_q != SK_DBG));
  assign vreg_en   = !(stopped && ((mode_q == SK_LIGHT) || (mode_q == SK_DEEP)));
  assign rst_req   = (state_q == ST_EXIT) && exit_rst_q;
  assign vec_req   = (state_q == ST_EXIT) && !exit_rst_q;
  assign rst_cause = cause_q;
  assign vec_src   = src_q;
  assign in_stop   = stopped;
  assign last_mode = last_q;

  for (genvar g = 0; g < NCLK; g++) begin : g_clk_gate
    assign clk_gate_en[g] = clocks_on;
  end

endmodule

// File: rtl/stopmode_ctrl_chk.sv
module stopmode_ctrl_chk #(
  parameter int unsigned NCLK = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NCLK-1:0] clk_gate_en,
  input logic            vreg_en,
  input logic            rst_req,
  input logic [1:0]      rst_cause,
  input logic            vec_req,
  input logic            in_stop,
  input logic [2:0]      last_mode
);

  assert_strobe_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(rst_req && vec_req));

  assert_dbg_clocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_stop && last_mode == 3'd1) |-> (&clk_gate_en && vreg_en));

  assert_reg_vreg_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_stop && last_mode == 3'd2) |-> (vreg_en && clk_gate_en == '0));

  assert_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_stop && (last_mode == 3'd3 || last_mode == 3'd4)) |-> (!vreg_en && clk_gate_en == '0));

  assert_cfg_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_stop && $past(in_stop)) |-> $stable(last_mode));

  assert_deep_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(in_stop) && last_mode == 3'd4) |=> (rst_req && !vec_req));

  assert_clk_first_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_req || vec_req) |-> $past(&clk_gate_en));

  assert_exit_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_stop) |=> (rst_req || vec_req));

  assert_rst_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

  assert_vec_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    vec_req |=> !vec_req);

  assert_cause_known_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> !$isunknown(rst_cause));

endmodule

bind stopmode_ctrl stopmode_ctrl_chk #(.NCLK(NCLK)) u_chk (.*);

// File: tb/stopmode_ctrl_tb.sv
module stopmode_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NPORT = 24;
  localparam int NCLK  = 4;
  localparam int IDXW  = $clog2(NPORT + 6);

  logic clk, rst_n, stop_req;
  logic cfg_stop_en, cfg_dbg_en, cfg_lvd_en, cfg_lvd_stop_en, cfg_pwr_down;
  logic pin_rst_n, wake_lvd_rst, wake_irq, wake_lvw, wake_adc, wake_rtc, wake_can, wake_sci;
  logic [NPORT-1:0] wake_port;
  logic [NCLK-1:0]  clk_gate_en;
  logic             vreg_en, rst_req, vec_req, in_stop;
  logic [1:0]       rst_cause;
  logic [IDXW-1:0]  vec_src;
  logic [2:0]       last_mode;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  stopmode_ctrl #(.NPORT(NPORT), .NCLK(NCLK)) u_dut (
    .clk(clk), .rst_n(rst_n), .stop_req(stop_req),
    .cfg_stop_en(cfg_stop_en), .cfg_dbg_en(cfg_dbg_en), .cfg_lvd_en(cfg_lvd_en),
    .cfg_lvd_stop_en(cfg_lvd_stop_en), .cfg_pwr_down(cfg_pwr_down),
    .pin_rst_n(pin_rst_n), .wake_lvd_rst(wake_lvd_rst), .wake_irq(wake_irq),
    .wake_port(wake_port), .wake_lvw(wake_lvw), .wake_adc(wake_adc),
    .wake_rtc(wake_rtc), .wake_can(wake_can), .wake_sci(wake_sci),
    .clk_gate_en(clk_gate_en), .vreg_en(vreg_en), .rst_req(rst_req),
    .rst_cause(rst_cause), .vec_req(vec_req), .vec_src(vec_src),
    .in_stop(in_stop), .last_mode(last_mode)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // cfg word: {stop_en, dbg_en, lvd_en, lvd_stop_en, pwr_down}
  function automatic logic [2:0] exp_mode(input logic [4:0] c);
    if (!c[4])          return 3'd0;
    else if (c[3])      return 3'd1;
    else if (c[2] && c[1]) return 3'd2;
    else if (c[0])      return 3'd4;
    else                return 3'd3;
  endfunction

  function automatic logic [31:0] exp_clk(input logic [2:0] m);
    return (m == 3'd1) ? 32'hF : 32'h0;
  endfunction

  function automatic logic exp_vreg(input logic [2:0] m);
    return (m == 3'd1) || (m == 3'd2);
  endfunction

  function automatic string mode_req(input logic [2:0] m);
    if (m == 3'd1) return "R2";
    if (m == 3'd2) return "R3";
    return "R4";
  endfunction

  // line index: 0 pin, 1 lvd reset, 2 irq, 3..26 ports, 27 lvw, 28 adc, 29 rtc, 30 can, 31 sci
  task automatic set_line(input int idx, input logic v);
    case (idx)
      0:  pin_rst_n    = ~v;
      1:  wake_lvd_rst = v;
      2:  wake_irq     = v;
      27: wake_lvw     = v;
      28: wake_adc     = v;
      29: wake_rtc     = v;
      30: wake_can     = v;
      31: wake_sci     = v;
      default: wake_port[idx-3] = v;
    endcase
  endtask

  task automatic clear_lines();
    pin_rst_n = 1'b1; wake_lvd_rst = 1'b0; wake_irq = 1'b0; wake_port = '0;
    wake_lvw = 1'b0; wake_adc = 1'b0; wake_rtc = 1'b0; wake_can = 1'b0; wake_sci = 1'b0;
  endtask

  task automatic set_cfg(input logic [4:0] c);
    {cfg_stop_en, cfg_dbg_en, cfg_lvd_en, cfg_lvd_stop_en, cfg_pwr_down} = c;
  endtask

  // enter stop; returns expected mode code; checks entry outputs
  task automatic enter(input logic [4:0] c, output logic [2:0] m);
    m = exp_mode(c);
    set_cfg(c);
    stop_req = 1'b1;
    @(negedge clk);
    stop_req = 1'b0;
    if (m == 3'd0) begin
      chk("R1", "rst_req", 32'(rst_req), 1);
      chk("R1", "rst_cause", 32'(rst_cause), 0);
      chk("R1", "clk_gate_en", 32'(clk_gate_en), 32'hF);
      chk("R1", "in_stop", 32'(in_stop), 0);
      @(negedge clk);
      chk("R1", "rst_req pulse", 32'(rst_req), 0);
    end else begin
      chk("R12", "in_stop", 32'(in_stop), 1);
      chk("R12", "last_mode", 32'(last_mode), 32'(m));
      chk(mode_req(m), "clk_gate_en", 32'(clk_gate_en), exp_clk(m));
      chk(mode_req(m), "vreg_en", 32'(vreg_en), 32'(exp_vreg(m)));
    end
  endtask

  // raise lines in mask, expect exit with given kind
  task automatic wake_expect(input logic [31:0] lines, input bit exp_rst,
                             input logic [1:0] ecause, input int esrc, input string req);
    for (int i = 0; i < 32; i++) if (lines[i]) set_line(i, 1'b1);
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    chk("R11", "clocks restored", 32'(clk_gate_en), 32'hF);
    chk("R11", "no early strobe", 32'(rst_req | vec_req), 0);
    @(negedge clk);
    chk(req, "rst_req", 32'(rst_req), 32'(exp_rst));
    chk(req, "vec_req", 32'(vec_req), 32'(!exp_rst));
    if (exp_rst) chk(req, "rst_cause", 32'(rst_cause), 32'(ecause));
    else         chk(req, "vec_src", 32'(vec_src), 32'(esrc));
    @(negedge clk);
    chk("R11", "strobes end", 32'(rst_req | vec_req), 0);
    chk("R12", "in_stop after exit", 32'(in_stop), 0);
    clear_lines();
    repeat (4) @(negedge clk);
  endtask

  task automatic exp_for(input int idx, input logic [2:0] m, output bit er,
                         output logic [1:0] ec, output int es, output string rq);
    es = 0; ec = 2'd0;
    if (idx == 0)      begin er = 1; ec = 2'd1; rq = "R6"; end
    else if (idx == 1) begin er = 1; ec = 2'd2; rq = "R6"; end
    else if (m == 3'd4) begin er = 1; ec = 2'd3; rq = "R8"; end
    else               begin er = 0; es = idx - 2; rq = "R7"; end
  endtask

  initial begin
    logic [2:0] m;
    logic [4:0] c;
    int s;
    bit er; logic [1:0] ec; int es; string rq;
    int seed_v;
    seed_v = $urandom(32'd4242);
    rst_n = 1'b0; stop_req = 1'b0; set_cfg(5'b0); clear_lines();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // reset state
    chk("R12", "reset last_mode", 32'(last_mode), 0);
    chk("R12", "reset in_stop", 32'(in_stop), 0);
    chk("R11", "reset clocks", 32'(clk_gate_en), 32'hF);
    chk("R11", "reset vreg", 32'(vreg_en), 1);
    chk("R11", "reset strobes", 32'(rst_req | vec_req), 0);

    // R7 priority: port5 (idx 8) and lvw (idx 27) together -> index 6
    enter(5'b10000, m);
    wake_expect((32'd1 << 8) | (32'd1 << 27), 0, 2'd0, 6, "R7");

    // R6 priority: pin and irq together -> pin cause
    enter(5'b10000, m);
    wake_expect(32'd1 | (32'd1 << 2), 1, 2'd1, 0, "R6");

    // R10: irq already high at entry does not wake
    set_line(2, 1'b1);
    repeat (4) @(negedge clk);
    enter(5'b10000, m);
    repeat (6) @(negedge clk);
    chk("R10", "held line no wake", 32'(in_stop), 1);
    wake_expect(32'd1 << 3, 0, 2'd0, 1, "R10");

    // R13: stop strobe while stopped ignored
    enter(5'b10001, m);
    set_cfg(5'b00000);
    stop_req = 1'b1;
    @(negedge clk);
    stop_req = 1'b0;
    chk("R13", "no illegal reset", 32'(rst_req), 0);
    @(negedge clk);
    chk("R13", "no illegal reset later", 32'(rst_req), 0);
    chk("R13", "still stopped", 32'(in_stop), 1);
    chk("R13", "mode kept", 32'(last_mode), 4);
    wake_expect(32'd1 << 31, 1, 2'd3, 0, "R8");

    // R9: ADC accepted when low-voltage detect kept
    enter(5'b10110, m);
    wake_expect(32'd1 << 28, 0, 2'd0, 26, "R9");

    // R2: debug overrides power-down and low-voltage bits
    enter(5'b11111, m);
    chk("R2", "mode debug", 32'(m), 1);
    wake_expect(32'd1 << 29, 0, 2'd0, 27, "R2");

    // constrained random trials
    for (int t = 0; t < 80; t++) begin
      c = 5'($urandom_range(0, 31));
      if ($urandom_range(0, 9) < 8) c[4] = 1'b1;
      if ($urandom_range(0, 1) == 1) c[3] = 1'b0;
      s = int'($urandom_range(0, 31));
      enter(c, m);
      if (m != 3'd0) begin
        set_cfg(~c);
        repeat (2) @(negedge clk);
        chk("R5", "last_mode held", 32'(last_mode), 32'(m));
        chk("R5", "clocks held", 32'(clk_gate_en), exp_clk(m));
        chk("R5", "vreg held", 32'(vreg_en), 32'(exp_vreg(m)));
        if (s == 28 && !(c[2] && c[1])) begin
          set_line(28, 1'b1);
          repeat (6) @(negedge clk);
          chk("R9", "adc ignored", 32'(in_stop), 1);
          s = 2;
        end
        exp_for(s, m, er, ec, es, rq);
        wake_expect(32'd1 << s, er, ec, es, rq);
      end else begin
        repeat (3) @(negedge clk);
      end
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule